// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block turns edges on a set of interrupt input pins into interrupt messages aimed at a group of processors. Each pin has a redirection entry, supplied as a flat input vector. The entry holds a vector number, a delivery mode, a destination mode, a destination byte, a polarity bit, a trigger bit and a mask bit. When a pin rises, the block records a pending request. It serves pending requests one per cycle, lowest pin number first. For each request it builds the message and works out the target bitmask over `NUM_CPUS` processors.

Destinations are resolved in one of two ways:
- **Physical mode:** processor `i` answers to ID `i`, and ID 0xFF reaches every processor.
- **Logical mode:** each processor's destination byte is compared with the message destination by bitwise AND.

Lowest-priority delivery does not compare priorities. It rotates a counter through the processors that match. The external-interrupt mode takes its vector from a legacy controller input instead of from the entry.

A single state register records the outcome of the request served in the previous cycle. The states are:
- `ST_IDLE`: nothing was served.
- `ST_SEND`: a message went out.
- `ST_DROP`: the entry was masked, or no processor was targeted.
- `ST_FAULT`: lowest-priority delivery was requested with physical destination mode.

Every cycle the next state is chosen from the request currently granted:
- No grant leads to `ST_IDLE`.
- A masked entry leads to `ST_DROP`.
- A bad configuration leads to `ST_FAULT`.
- An empty target set leads to `ST_DROP`.
- Anything else leads to `ST_SEND`.

Any state can move to any other state.

Top module: `irq_route_engine`

## Requirements
- R1: A pin fires only when it is high now and was low at the previous clock edge. The message appears (`msg_valid` high for one cycle) after the second rising clock edge that follows the pin going high. Holding the pin high produces no further message. Lowering it and raising it again produces a new message.
- R2: An entry whose mask bit (bit 14) is 1 produces neither `msg_valid` nor `cfg_error`.
- R3: When the delivery mode (entry bits 10:8) is 7 (external interrupt), `msg_vector` equals `ext_vector`. For every other mode it equals entry bits 7:0. The mode codes are: 0 fixed, 1 lowest priority, 2 SMI, 4 NMI, 5 INIT, 7 external interrupt.
- R4: The message copies its fields from the entry as follows:
  - `msg_dest` from bits 22:15
  - `msg_dmode` from bits 10:8
  - `msg_dstmode` from bit 11 (1 means logical)
  - `msg_level` from the polarity bit 12
  - `msg_trigger` from bit 13
- R5: In physical mode (bit 11 = 0), destination 0xFF sets every bit of `msg_targets`.
- R6: In physical mode, any other destination D sets only bit D of `msg_targets`. If D is not below `NUM_CPUS`, no message is issued.
- R7: In logical mode, bit i of `msg_targets` is set when processor i's byte in `cpu_ldest` (bits 8i+7:8i) ANDed with the destination is nonzero.
- R8: A request whose target set is empty issues no `msg_valid`, so every message has at least one target.
- R9: For lowest-priority delivery in logical mode with at least one match, exactly one target is set. It is the match at position (counter mod match count), counting in ascending processor order. The counter starts at 0 at reset and increments only after such a delivery.
- R10: Lowest-priority delivery in physical mode pulses `cfg_error` for one cycle instead of a message, and leaves the rotation counter unchanged.
- R11: Pins that rise in the same cycle are all served, lowest pin number first, one message per cycle on consecutive cycles. `msg_pin` names the pin that was served.
- R12: After reset, `msg_valid`, `cfg_error` and `msg_targets` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | NUM_PINS | Interrupt input pins |
| redir_flat | input | NUM_PINS*23 | Redirection entries, pin p at bits 23p+22:23p |
| cpu_ldest | input | NUM_CPUS*8 | Logical-destination byte of each processor |
| ext_vector | input | 8 | Vector from the legacy controller |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_dstmode | output | 1 | Message destination mode |
| msg_dest | output | 8 | Message destination |
| msg_level | output | 1 | Message level bit |
| msg_trigger | output | 1 | Message trigger bit |
| msg_targets | output | NUM_CPUS | Target processor bitmask |
| msg_pin | output | $clog2(NUM_PINS) | Pin that produced the message |
| cfg_error | output | 1 | Pulse for an unsupported configuration |

## Verification
Two things can happen in the same cycle: a pending request is granted and cleared, and fresh edges are captured on other pins. The bench provokes this by raising three unordered pins at one falling edge. It then expects three consecutive strobes in ascending pin order, with matching vectors, and a quiet cycle afterwards. The rotation counter also advances in the same cycle that a lowest-priority message is registered. Successive deliveries are therefore checked against a counter-mod-count prediction kept in the bench, including one request that matches nothing and must not advance the counter.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam logic [2:0] DM_FIXED  = 3'd0;
    localparam logic [2:0] DM_LOWPRI = 3'd1;
    localparam logic [2:0] DM_SMI    = 3'd2;
    localparam logic [2:0] DM_NMI    = 3'd4;
    localparam logic [2:0] DM_INIT   = 3'd5;
    localparam logic [2:0] DM_EXTINT = 3'd7;

    localparam logic [7:0] DEST_ALL = 8'hFF;

    typedef struct packed {
        logic [7:0] dest;
        logic       masked;
        logic       trig;
        logic       pol;
        logic       logical;
        logic [2:0] dmode;
        logic [7:0] vec;
    } redir_t;

    localparam int ENT_W = $bits(redir_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_DROP  = 2'd2,
        ST_FAULT = 2'd3
    } eng_state_e;

endpackage

// File: rtl/irq_edge_queue.sv
module irq_edge_queue #(
    parameter int NUM_PINS = 8,
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins,
    output logic                grant_vld,
    output logic [PIN_W-1:0]    grant_idx
);

    logic [NUM_PINS-1:0] pin_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] grant_oh;

    assign rise = pins & ~pin_q;

    // lowest pending index wins: scan downwards, last hit stays
    always_comb begin
        grant_vld = 1'b0;
        grant_idx = '0;
        grant_oh  = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant_vld   = 1'b1;
                grant_idx   = PIN_W'(i);
                grant_oh    = '0;
                grant_oh[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= '0;
            pend_q <= '0;
        end else begin
            pin_q  <= pins;
            pend_q <= (pend_q & ~grant_oh) | rise;
        end
    end

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int NUM_CPUS = 4,
    parameter int RR_W     = 8
) (
    input  logic [NUM_CPUS-1:0] cand,
    input  logic [RR_W-1:0]     cnt,
    output logic [NUM_CPUS-1:0] pick_oh
);

    localparam int CW = $clog2(NUM_CPUS + 1);

    logic [CW-1:0]   n_set;
    logic [RR_W-1:0] slot;
    logic [RR_W-1:0] seen;

    always_comb begin
        n_set = CW'($countones(cand));
        slot  = (n_set == '0) ? '0 : (cnt % RR_W'(n_set));
    end

    always_comb begin
        pick_oh = '0;
        seen    = '0;
        for (int i = 0; i < NUM_CPUS; i++) begin
            if (cand[i]) begin
                if (seen == slot) pick_oh[i] = 1'b1;
                seen = seen + 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_target_resolve.sv
module irq_target_resolve
    import irq_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int RR_W     = 8
) (
    input  logic [7:0]            dest,
    input  logic                  logical,
    input  logic [2:0]            dmode,
    input  logic [NUM_CPUS*8-1:0] ldest_top,
    input  logic [RR_W-1:0]       rr_cnt,
    output logic [NUM_CPUS-1:0]   targets,
    output logic                  lp_event,
    output logic                  bad_cfg
);

    logic [NUM_CPUS-1:0] logic_hit;
    logic [NUM_CPUS-1:0] phys_hit;
    logic [NUM_CPUS-1:0] lp_oh;
    logic                is_lp;

    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_cpu
        assign logic_hit[g] = |(ldest_top[g*8 +: 8] & dest);
        assign phys_hit[g]  = (dest == 8'(g));
    end

    irq_rr_pick #(.NUM_CPUS(NUM_CPUS), .RR_W(RR_W)) u_pick (
        .cand    (logic_hit),
        .cnt     (rr_cnt),
        .pick_oh (lp_oh)
    );

    always_comb begin
        is_lp    = (dmode == DM_LOWPRI);
        bad_cfg  = !logical && is_lp;
        lp_event = logical && is_lp && (|logic_hit);
        if (!logical) begin
            if (is_lp)                 targets = '0;
            else if (dest == DEST_ALL) targets = '1;
            else                       targets = phys_hit;
        end else begin
            targets = is_lp ? lp_oh : logic_hit;
        end
    end

endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
    import irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_CPUS = 4,
    parameter int RR_W     = 8,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       irq_pins,
    input  logic [NUM_PINS*ENT_W-1:0] redir_flat,
    input  logic [NUM_CPUS*8-1:0]     cpu_ldest,
    input  logic [7:0]                ext_vector,
    output logic                      msg_valid,
    output logic [7:0]                msg_vector,
    output logic [2:0]                msg_dmode,
    output logic                      msg_dstmode,
    output logic [7:0]                msg_dest,
    output logic                      msg_level,
    output logic                      msg_trigger,
    output logic [NUM_CPUS-1:0]       msg_targets,
    output logic [PIN_W-1:0]          msg_pin,
    output logic                      cfg_error
);

    logic                grant_vld;
    logic [PIN_W-1:0]    grant_idx;
    redir_t              ent;
    logic [7:0]          vec_sel;
    logic [NUM_CPUS-1:0] tgt_sel;
    logic                lp_event;
    logic                bad_cfg;
    logic [RR_W-1:0]     rr_q;
    eng_state_e          st_q, st_d;

    irq_edge_queue #(.NUM_PINS(NUM_PINS)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (irq_pins),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    assign ent     = redir_t'(redir_flat[grant_idx*ENT_W +: ENT_W]);
    assign vec_sel = (ent.dmode == DM_EXTINT) ? ext_vector : ent.vec;

    irq_target_resolve #(.NUM_CPUS(NUM_CPUS), .RR_W(RR_W)) u_resolve (
        .dest      (ent.dest),
        .logical   (ent.logical),
        .dmode     (ent.dmode),
        .ldest_top (cpu_ldest),
        .rr_cnt    (rr_q),
        .targets   (tgt_sel),
        .lp_event  (lp_event),
        .bad_cfg   (bad_cfg)
    );

    // next outcome from the request granted this cycle
    always_comb begin
        if (!grant_vld)          st_d = ST_IDLE;
        else if (ent.masked)     st_d = ST_DROP;
        else if (bad_cfg)        st_d = ST_FAULT;
        else if (tgt_sel == '0)  st_d = ST_DROP;
        else                     st_d = ST_SEND;
    end

    // state register with message and rotation storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            rr_q        <= '0;
            msg_vector  <= '0;
            msg_dmode   <= '0;
            msg_dstmode <= 1'b0;
            msg_dest    <= '0;
            msg_level   <= 1'b0;
            msg_trigger <= 1'b0;
            msg_targets <= '0;
            msg_pin     <= '0;
        end else begin
            st_q <= st_d;
            if (st_d == ST_SEND) begin
                msg_vector  <= vec_sel;
                msg_dmode   <= ent.dmode;
                msg_dstmode <= ent.logical;
                msg_dest    <= ent.dest;
                msg_level   <= ent.pol;
                msg_trigger <= ent.trig;
                msg_targets <= tgt_sel;
                msg_pin     <= grant_idx;
                if (lp_event) rr_q <= rr_q + 1'b1;
            end
        end
    end

    // strobes decoded from the state
    always_comb begin
        msg_valid = 1'b0;
        cfg_error = 1'b0;
        unique case (st_q)
            ST_IDLE:  ;
            ST_SEND:  msg_valid = 1'b1;
            ST_DROP:  ;
            ST_FAULT: cfg_error = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          ext_vector,
    input logic                msg_valid,
    input logic [7:0]          msg_vector,
    input logic [2:0]          msg_dmode,
    input logic                msg_dstmode,
    input logic [7:0]          msg_dest,
    input logic [NUM_CPUS-1:0] msg_targets
);

    // R8
    valid_has_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_targets != '0));

    // R5
    bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_dstmode && msg_dest == DEST_ALL) |-> (msg_targets == {NUM_CPUS{1'b1}}));

    // R6
    phys_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_dstmode && msg_dest != DEST_ALL) |-> ($countones(msg_targets) == 1));

    // R9
    lowpri_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_dmode == DM_LOWPRI) |-> ($countones(msg_targets) == 1));

    // R10
    lowpri_logical_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_dmode == DM_LOWPRI) |-> msg_dstmode);

    // R3
    ext_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_dmode == DM_EXTINT) |-> (msg_vector == $past(ext_vector)));

endmodule

bind irq_route_engine irq_route_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_vector  (ext_vector),
    .msg_valid   (msg_valid),
    .msg_vector  (msg_vector),
    .msg_dmode   (msg_dmode),
    .msg_dstmode (msg_dstmode),
    .msg_dest    (msg_dest),
    .msg_targets (msg_targets)
);

// File: tb/irq_route_engine_tb.sv
module irq_route_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NC = 4;
    localparam int EW = 23;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     irq_pins = '0;
    logic [NP*EW-1:0]  redir_flat = '0;
    logic [NC*8-1:0]   cpu_ldest = '0;
    logic [7:0]        ext_vector = '0;
    logic              msg_valid;
    logic [7:0]        msg_vector;
    logic [2:0]        msg_dmode;
    logic              msg_dstmode;
    logic [7:0]        msg_dest;
    logic              msg_level;
    logic              msg_trigger;
    logic [NC-1:0]     msg_targets;
    logic [2:0]        msg_pin;
    logic              cfg_error;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_engine #(.NUM_PINS(NP), .NUM_CPUS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .redir_flat(redir_flat),
        .cpu_ldest(cpu_ldest), .ext_vector(ext_vector), .msg_valid(msg_valid),
        .msg_vector(msg_vector), .msg_dmode(msg_dmode), .msg_dstmode(msg_dstmode),
        .msg_dest(msg_dest), .msg_level(msg_level), .msg_trigger(msg_trigger),
        .msg_targets(msg_targets), .msg_pin(msg_pin), .cfg_error(cfg_error)
    );

    function automatic logic [EW-1:0] mk(input logic [7:0] dest, input logic msk,
        input logic trig, input logic pol, input logic lg, input logic [2:0] dm,
        input logic [7:0] vec);
        return {dest, msk, trig, pol, lg, dm, vec};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ent(input int p, input logic [EW-1:0] e);
        @(negedge clk);
        redir_flat[p*EW +: EW] = e;
    endtask

    // raise pin, sample just after the second rising edge
    task automatic fire(input int p);
        @(negedge clk);
        irq_pins[p] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic drop_pin(input int p);
        @(negedge clk);
        irq_pins[p] = 1'b0;
        repeat (2) @(posedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R12 valid", 32'(msg_valid), 0);
        chk("R12 error", 32'(cfg_error), 0);
        chk("R12 targets", 32'(msg_targets), 0);
    endtask

    task automatic t_edge();
        int seen;
        set_ent(0, mk(8'd2, 0, 0, 0, 0, 3'd0, 8'h31));
        fire(0);
        chk("R1 first", 32'(msg_valid), 1);
        chk("R1 targets", 32'(msg_targets), 32'h4);
        chk("R3 vector", 32'(msg_vector), 32'h31);
        seen = 0;
        repeat (6) begin
            @(posedge clk); #1;
            seen += int'(msg_valid);
        end
        chk("R1 held", 32'(seen), 0);
        drop_pin(0);
        fire(0);
        chk("R1 rearm", 32'(msg_valid), 1);
        drop_pin(0);
    endtask

    task automatic t_mask();
        set_ent(1, mk(8'd1, 1, 0, 0, 0, 3'd0, 8'h22));
        fire(1);
        chk("R2 valid", 32'(msg_valid), 0);
        chk("R2 error", 32'(cfg_error), 0);
        drop_pin(1);
    endtask

    task automatic t_vector();
        @(negedge clk) ext_vector = 8'hA5;
        set_ent(2, mk(8'd0, 0, 0, 0, 0, 3'd7, 8'h11));
        fire(2);
        chk("R3 ext valid", 32'(msg_valid), 1);
        chk("R3 ext vector", 32'(msg_vector), 32'hA5);
        drop_pin(2);
        set_ent(2, mk(8'd0, 0, 0, 0, 0, 3'd4, 8'h11));
        fire(2);
        chk("R3 nmi vector", 32'(msg_vector), 32'h11);
        drop_pin(2);
    endtask

    task automatic t_fields();
        set_ent(3, mk(8'd1, 0, 1, 1, 0, 3'd5, 8'h7E));
        fire(3);
        chk("R4 valid", 32'(msg_valid), 1);
        chk("R4 dest", 32'(msg_dest), 1);
        chk("R4 dmode", 32'(msg_dmode), 5);
        chk("R4 dstmode", 32'(msg_dstmode), 0);
        chk("R4 level", 32'(msg_level), 1);
        chk("R4 trigger", 32'(msg_trigger), 1);
        drop_pin(3);
    endtask

    task automatic t_physical();
        set_ent(4, mk(8'hFF, 0, 0, 0, 0, 3'd0, 8'h40));
        fire(4);
        chk("R5 broadcast", 32'(msg_targets), 32'hF);
        drop_pin(4);
        set_ent(4, mk(8'd3, 0, 0, 0, 0, 3'd0, 8'h40));
        fire(4);
        chk("R6 single", 32'(msg_targets), 32'h8);
        drop_pin(4);
        set_ent(4, mk(8'd9, 0, 0, 0, 0, 3'd0, 8'h40));
        fire(4);
        chk("R6 absent id", 32'(msg_valid), 0);
        drop_pin(4);
    endtask

    task automatic t_logical();
        @(negedge clk) cpu_ldest = {8'h08, 8'h05, 8'h02, 8'h01};
        set_ent(5, mk(8'h01, 0, 0, 0, 1, 3'd0, 8'h50));
        fire(5);
        chk("R7 match", 32'(msg_targets), 32'h5);
        drop_pin(5);
        set_ent(5, mk(8'h10, 0, 0, 0, 1, 3'd0, 8'h50));
        fire(5);
        chk("R8 no target", 32'(msg_valid), 0);
        drop_pin(5);
    endtask

    task automatic t_lpphys();
        set_ent(6, mk(8'd1, 0, 0, 0, 0, 3'd1, 8'h60));
        fire(6);
        chk("R10 error", 32'(cfg_error), 1);
        chk("R10 valid", 32'(msg_valid), 0);
        @(posedge clk); #1;
        chk("R10 pulse", 32'(cfg_error), 0);
        drop_pin(6);
    endtask

    task automatic t_lowpri();
        logic [3:0] exp_seq [4] = '{4'h1, 4'h4, 4'h1, 4'h4};
        for (int k = 0; k < 3; k++) begin
            set_ent(7, mk(8'h01, 0, 0, 0, 1, 3'd1, 8'h70));
            fire(7);
            chk("R9 rotate", 32'(msg_targets), 32'(exp_seq[k]));
            drop_pin(7);
        end
        set_ent(7, mk(8'h10, 0, 0, 0, 1, 3'd1, 8'h70));
        fire(7);
        chk("R9 no match", 32'(msg_valid), 0);
        drop_pin(7);
        set_ent(7, mk(8'h01, 0, 0, 0, 1, 3'd1, 8'h70));
        fire(7);
        chk("R9 counter held", 32'(msg_targets), 32'(exp_seq[3]));
        drop_pin(7);
    endtask

    task automatic t_multi();
        set_ent(2, mk(8'd0, 0, 0, 0, 0, 3'd0, 8'h42));
        set_ent(5, mk(8'd1, 0, 0, 0, 0, 3'd0, 8'h45));
        set_ent(6, mk(8'd2, 0, 0, 0, 0, 3'd0, 8'h46));
        @(negedge clk);
        irq_pins[2] = 1'b1; irq_pins[5] = 1'b1; irq_pins[6] = 1'b1;
        @(posedge clk);
        @(posedge clk); #1;
        chk("R11 first pin", 32'(msg_pin), 2);
        chk("R11 first vec", 32'(msg_vector), 32'h42);
        @(posedge clk); #1;
        chk("R11 second valid", 32'(msg_valid), 1);
        chk("R11 second pin", 32'(msg_pin), 5);
        @(posedge clk); #1;
        chk("R11 third pin", 32'(msg_pin), 6);
        chk("R11 third vec", 32'(msg_vector), 32'h46);
        @(posedge clk); #1;
        chk("R11 drained", 32'(msg_valid), 0);
        @(negedge clk) irq_pins = '0;
        repeat (2) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_edge();
        t_mask();
        t_vector();
        t_fields();
        t_physical();
        t_logical();
        t_lpphys();
        t_lowpri();
        t_multi();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule